// File: doc/BRIEF.md
# SuperSpeed PHY Power-Up Sequencer

This block brings a SuperSpeed PHY from reset to a tuned, running state with no software involvement. After a start pulse it holds the PHY in reset for a fixed time. It then selects the reference source and waits for the reference clock to settle. Next it turns on the PHY and lane-0 power together. Last, it patches a fixed list of internal PHY registers through a control-register master port. All timing is counted in reference-clock cycles, derived from the parameter `REF_HZ`.

Every internal read uses a known workaround: the read command is issued twice and only the second result is kept. Each command on the port is followed by a poll of the port's busy flag. If the flag stays busy for too long, the run is aborted and an error flag is held. A single-cycle done pulse marks a good finish. Tuning values come from input pins, or from built-in defaults when `tune_default` is high.

Top module: `ssphy_powerup_seq`

## Requirements
- R1: After `rst_n` is released, every output is low. This covers `phy_reset`, `ref_pad_sel`, `phy_en`, `lane_pwr`, `cr_req`, `done` and `err`.
- R2: A `start` pulse seen while idle raises `phy_reset` on the next edge. `phy_reset` then stays high for exactly RST_CYC = (REF_HZ/1000)*RESET_US/1000 cycles.
- R3: `ref_pad_sel` is updated when reset is released.
  - It takes the value `xo_present` had at start.
  - `phy_en` and `lane_pwr` rise together exactly SET_CYC = (REF_HZ/1000)*SETTLE_US/1000 cycles after reset release, and never while `phy_reset` is high.
- R4: `cr_cmd` encodes 0 as capture address, 1 as capture data, 2 as read and 3 as write. `cr_wdata` carries the address or the data.
  - A patch that reads first issues this sequence: capture address, read, read, capture address, capture data, write.
  - Only the data from the second read is merged.
  - `cr_req` is a single-cycle pulse.
- R5: The patches run in a fixed order, to these addresses: 0x102D, 0x1010, 0x1006, 0x1002, then 0x0030. The last one is a plain write with no read.
- R6: Each patch merges new bits into the value it read back:
  - 0x102D sets bit 7.
  - 0x1010 clears bits [11:4] and then ORs in 0x20.
  - 0x1006 clears bit 6, sets bits 7 and 11, and loads the eq value into bits [10:8].
  - 0x1002 loads the de-emphasis value into [13:7] and 0x6E into [6:0], sets bit 14, and keeps bit 15.
  - 0x0030 receives the mpll value.
- R7: The tuning inputs (eq 3 bits, de-emphasis 7 bits, mpll) are sampled at start. With `tune_default` high at start, the values used are eq=4, de-emphasis=23 and mpll=0.
- R8: After each request, `cr_busy` is sampled on every cycle from the next one on, and the sequence moves on at the first sample that is not busy.
  - After POLL_LIMIT (10) busy samples in a row, `err` rises and no further request is issued.
  - `err` then holds until the next start, which clears it.
- R9: `done` pulses for exactly one cycle, on the cycle after the final write's busy flag is seen clear. `done` and `err` are never high together.
- R10: A `start` pulse while a sequence is running is ignored. In particular, it does not lengthen the reset phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the power-up sequence |
| xo_present | input | 1 | External crystal reference is present |
| tune_default | input | 1 | Use built-in tuning values |
| tune_eq | input | 3 | Receive equaliser value |
| tune_deemph | input | 7 | Transmit de-emphasis value |
| tune_mpll | input | CR_W | PLL setting written to 0x0030 |
| phy_reset | output | 1 | PHY reset |
| ref_pad_sel | output | 1 | Select the reference pad clock |
| phy_en | output | 1 | PHY enable |
| lane_pwr | output | 1 | Lane-0 power present |
| cr_req | output | 1 | Control-register command strobe |
| cr_cmd | output | 2 | Command code |
| cr_wdata | output | CR_W | Address or data for the command |
| cr_busy | input | 1 | Command still latching |
| cr_rdata | input | CR_W | Read result |
| done | output | 1 | Sequence finished, one-cycle pulse |
| err | output | 1 | Latch timeout, held until next start |

## Verification
The bench models the PHY register port. In that model, the first read after each address capture returns corrupted data. A design that merged the first read would therefore leave wrong values in the patched registers.

The latency of the busy flag is tested at nine polls, which must pass, and at ten, which must time out. A timeout is forced both on the very first command and in the middle of a write. An off-by-one in the poll counter, or a sequence that keeps issuing commands after the abort, shows up as a wrong `err` state or as extra requests.

Reset and settle lengths are counted cycle by cycle. A second `start` arrives in the middle of the reset phase, which catches a design that restarts its timer. Runs with and without defaults and with random tuning values catch fields that are placed or masked wrongly.

// File: rtl/ssphy_powerup_seq.sv
module ssphy_powerup_seq #(
  parameter longint REF_HZ     = 125_000_000,
  parameter int     RESET_US   = 2000,
  parameter int     SETTLE_US  = 30000,
  parameter int     POLL_LIMIT = 10,
  parameter int     CR_W       = 16,
  parameter logic [2:0] DEF_EQ     = 3'd4,
  parameter logic [6:0] DEF_DEEMPH = 7'd23,
  parameter logic [CR_W-1:0] DEF_MPLL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            xo_present,
  input  logic            tune_default,
  input  logic [2:0]      tune_eq,
  input  logic [6:0]      tune_deemph,
  input  logic [CR_W-1:0] tune_mpll,
  output logic            phy_reset,
  output logic            ref_pad_sel,
  output logic            phy_en,
  output logic            lane_pwr,
  output logic            cr_req,
  output logic [1:0]      cr_cmd,
  output logic [CR_W-1:0] cr_wdata,
  input  logic            cr_busy,
  input  logic [CR_W-1:0] cr_rdata,
  output logic            done,
  output logic            err
);
  localparam longint RST_CYC = (REF_HZ / 1000) * RESET_US / 1000;
  localparam longint SET_CYC = (REF_HZ / 1000) * SETTLE_US / 1000;
  localparam longint TMAX    = (RST_CYC > SET_CYC) ? RST_CYC : SET_CYC;
  localparam int     TW      = $clog2(TMAX + 1);
  localparam int     PW      = $clog2(POLL_LIMIT + 1);
  localparam int     NPATCH  = 5;
  localparam logic [2:0] LAST = 3'(NPATCH - 1);

  localparam logic [1:0] C_ADDR = 2'd0, C_DATA = 2'd1, C_RD = 2'd2, C_WR = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_SETTLE, S_ISSUE, S_WAIT} st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [PW-1:0]   polls;
  logic [2:0]      pidx, step;
  logic [CR_W-1:0] rbuf, mpll_q, addr, merged;
  logic [2:0]      eq_q;
  logic [6:0]      de_q;
  logic            xo_q;

  always_comb begin
    case (pidx)
      3'd0:    addr = CR_W'(16'h102D);
      3'd1:    addr = CR_W'(16'h1010);
      3'd2:    addr = CR_W'(16'h1006);
      3'd3:    addr = CR_W'(16'h1002);
      default: addr = CR_W'(16'h0030);
    endcase
  end

  always_comb begin
    case (pidx)
      3'd0:    merged = rbuf | CR_W'(16'h0080);
      3'd1:    merged = (rbuf & ~CR_W'(16'h0FF0)) | CR_W'(16'h0020);
      3'd2:    merged = (rbuf & ~CR_W'(16'h0FC0)) | CR_W'(16'h0880) | (CR_W'(eq_q) << 8);
      3'd3:    merged = (rbuf & ~CR_W'(16'h7FFF)) | CR_W'(16'h4000) | (CR_W'(de_q) << 7) | CR_W'(16'h006E);
      default: merged = mpll_q;
    endcase
  end

  always_comb begin
    case (step)
      3'd0, 3'd3: cr_cmd = C_ADDR;
      3'd1, 3'd2: cr_cmd = C_RD;
      3'd4:       cr_cmd = C_DATA;
      default:    cr_cmd = C_WR;
    endcase
  end

  assign cr_wdata = (step == 3'd0 || step == 3'd3) ? addr :
                    (step == 3'd4) ? merged : '0;
  assign cr_req   = (st == S_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      polls <= '0;
      pidx <= '0;
      step <= '0;
      rbuf <= '0;
      mpll_q <= '0;
      eq_q <= '0;
      de_q <= '0;
      xo_q <= 1'b0;
      phy_reset <= 1'b0;
      ref_pad_sel <= 1'b0;
      phy_en <= 1'b0;
      lane_pwr <= 1'b0;
      done <= 1'b0;
      err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          err <= 1'b0;
          phy_reset <= 1'b1;
          phy_en <= 1'b0;
          lane_pwr <= 1'b0;
          xo_q <= xo_present;
          eq_q <= tune_default ? DEF_EQ : tune_eq;
          de_q <= tune_default ? DEF_DEEMPH : tune_deemph;
          mpll_q <= tune_default ? DEF_MPLL : tune_mpll;
          tmr <= TW'(RST_CYC - 1);
          st <= S_RST;
        end
        S_RST: begin
          if (tmr == '0) begin
            phy_reset <= 1'b0;
            ref_pad_sel <= xo_q;
            tmr <= TW'(SET_CYC - 1);
            st <= S_SETTLE;
          end else tmr <= tmr - 1'b1;
        end
        S_SETTLE: begin
          if (tmr == '0) begin
            phy_en <= 1'b1;
            lane_pwr <= 1'b1;
            pidx <= '0;
            step <= '0;
            st <= S_ISSUE;
          end else tmr <= tmr - 1'b1;
        end
        S_ISSUE: begin
          polls <= '0;
          st <= S_WAIT;
        end
        S_WAIT: begin
          if (!cr_busy) begin
            if (step == 3'd2) rbuf <= cr_rdata;
            if (step == 3'd5) begin
              if (pidx == LAST) begin
                done <= 1'b1;
                st <= S_IDLE;
              end else begin
                pidx <= pidx + 1'b1;
                step <= (pidx + 1'b1 == LAST) ? 3'd3 : 3'd0;
                st <= S_ISSUE;
              end
            end else begin
              step <= step + 1'b1;
              st <= S_ISSUE;
            end
          end else if (polls == PW'(POLL_LIMIT - 1)) begin
            err <= 1'b1;
            st <= S_IDLE;
          end else polls <= polls + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_reset_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_reset) |-> $past(start));
  assert_en_outside_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phy_en |-> !phy_reset);
  assert_lane_with_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_en) |-> $rose(lane_pwr));
  assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cr_req |=> !cr_req);
  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (polls < PW'(POLL_LIMIT)));
  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);
  assert_quiet_after_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !cr_req);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

// File: tb/ssphy_powerup_seq_test.sv
module ssphy_powerup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam longint REF_HZ = 100_000;
  localparam int RST_CYC = 200;
  localparam int SET_CYC = 3000;

  logic clk = 0, rst_n = 0, start = 0, xo_present = 0, tune_default = 0;
  logic [2:0] tune_eq = 0;
  logic [6:0] tune_deemph = 0;
  logic [15:0] tune_mpll = 0;
  logic phy_reset, ref_pad_sel, phy_en, lane_pwr, cr_req, cr_busy, done, err;
  logic [1:0] cr_cmd;
  logic [15:0] cr_wdata, cr_rdata;

  int checks = 0, fails = 0;

  ssphy_powerup_seq #(.REF_HZ(REF_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .xo_present(xo_present),
    .tune_default(tune_default), .tune_eq(tune_eq), .tune_deemph(tune_deemph),
    .tune_mpll(tune_mpll), .phy_reset(phy_reset), .ref_pad_sel(ref_pad_sel),
    .phy_en(phy_en), .lane_pwr(lane_pwr), .cr_req(cr_req), .cr_cmd(cr_cmd),
    .cr_wdata(cr_wdata), .cr_busy(cr_busy), .cr_rdata(cr_rdata),
    .done(done), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY register port model
  logic [15:0] mem [6];
  logic [15:0] init [6];
  logic [15:0] wr_log [8];
  logic [15:0] cap_addr, cap_data;
  logic load = 0, first_rd;
  int lat = 0, slow_from = 1000, req_n = 0, rd_n = 0, wr_n = 0;
  int busy_cnt = 0;
  assign cr_busy = (busy_cnt != 0);

  function automatic int idx(input logic [15:0] a);
    case (a)
      16'h102D: return 0;
      16'h1010: return 1;
      16'h1006: return 2;
      16'h1002: return 3;
      16'h0030: return 4;
      default:  return 5;
    endcase
  endfunction

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < 6; i++) mem[i] <= init[i];
      req_n <= 0; rd_n <= 0; wr_n <= 0; busy_cnt <= 0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (cr_req) begin
        busy_cnt <= (req_n >= slow_from) ? 10 : lat;
        req_n <= req_n + 1;
        case (cr_cmd)
          2'd0: begin cap_addr <= cr_wdata; first_rd <= 1'b1; end
          2'd1: cap_data <= cr_wdata;
          2'd2: begin
            cr_rdata <= first_rd ? (mem[idx(cap_addr)] ^ 16'hA5A5) : mem[idx(cap_addr)];
            first_rd <= 1'b0;
            rd_n <= rd_n + 1;
          end
          default: begin
            mem[idx(cap_addr)] <= cap_data;
            if (wr_n < 8) wr_log[wr_n] <= cap_addr;
            wr_n <= wr_n + 1;
          end
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_val(input int i, input logic [15:0] d,
      input logic [2:0] eq, input logic [6:0] de, input logic [15:0] mp);
    case (i)
      0: return {d[15:8], 1'b1, d[6:0]};
      1: return {d[15:12], 8'h02, d[3:0]};
      2: return {d[15:12], 1'b1, eq, 1'b1, 1'b0, d[5:0]};
      3: return {d[15], 1'b1, de, 7'h6E};
      default: return mp;
    endcase
  endfunction

  function automatic logic [15:0] addr_of(input int i);
    case (i)
      0: return 16'h102D;
      1: return 16'h1010;
      2: return 16'h1006;
      3: return 16'h1002;
      default: return 16'h0030;
    endcase
  endfunction

  task automatic run(input bit xo, input bit dflt, input logic [2:0] eq, input logic [6:0] de,
                     input logic [15:0] mp, input int lat_v, input int slow_v, input bit restart);
    int r, s, n;
    bit got_done, got_err;
    logic [2:0] eeq;
    logic [6:0] ede;
    logic [15:0] emp;
    @(negedge clk);
    for (int i = 0; i < 6; i++) init[i] = 16'($urandom);
    lat = lat_v; slow_from = slow_v;
    xo_present = xo; tune_default = dflt; tune_eq = eq; tune_deemph = de; tune_mpll = mp;
    load = 1; @(negedge clk); load = 0;
    start = 1; @(negedge clk); start = 0;
    chk(err == 0, "R8 err cleared by start", err, 0);
    xo_present = ~xo; tune_eq = ~eq; tune_deemph = ~de; tune_mpll = ~mp; tune_default = ~dflt;
    r = 0;
    while (phy_reset && r < 10000) begin
      r++;
      if (restart && r == 50) start = 1;
      if (r == 51) start = 0;
      @(negedge clk);
    end
    chk(r == RST_CYC, restart ? "R10 restart ignored" : "R2 reset length", r, RST_CYC);
    chk(ref_pad_sel == xo, "R3 ref pad select", ref_pad_sel, xo);
    s = 0;
    while (!phy_en && s < 10000) begin s++; @(negedge clk); end
    chk(s == SET_CYC, "R3 settle length", s, SET_CYC);
    chk(lane_pwr == 1'b1, "R3 lane power with enable", lane_pwr, 1);
    got_done = 0; got_err = 0; n = 0;
    while (!got_done && !got_err && n < 3000) begin
      @(negedge clk); n++;
      got_done = done; got_err = err;
    end
    eeq = dflt ? 3'd4 : eq; ede = dflt ? 7'd23 : de; emp = dflt ? 16'h0000 : mp;
    if (slow_v >= 1000) begin
      chk(got_done && !got_err, "R9 done reached", {got_err, got_done}, 2'b01);
      @(negedge clk);
      chk(done == 0, "R9 done single cycle", done, 0);
      for (int i = 0; i < 5; i++)
        chk(mem[i] == expect_val(i, init[i], eeq, ede, emp), dflt ? "R7 default tuning" : "R6 merged value",
            mem[i], expect_val(i, init[i], eeq, ede, emp));
      chk(rd_n == 8, "R4 two reads per patch", rd_n, 8);
      chk(wr_n == 5, "R5 write count", wr_n, 5);
      for (int i = 0; i < 5; i++)
        chk(wr_log[i] == addr_of(i), "R5 patch order", wr_log[i], addr_of(i));
    end else begin
      chk(got_err && !got_done, "R8 timeout raises err", {got_err, got_done}, 2'b10);
      n = req_n;
      repeat (40) @(negedge clk);
      chk(req_n == n, "R8 no requests after timeout", req_n, n);
      chk(err == 1, "R8 err held", err, 1);
      chk(wr_n == 0, "R8 no write before abort", wr_n, 0);
      chk(mem[0] == init[0], "R8 register untouched", mem[0], init[0]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({phy_reset, ref_pad_sel, phy_en, lane_pwr, cr_req, done, err} == 0, "R1 reset state",
        {phy_reset, ref_pad_sel, phy_en, lane_pwr, cr_req, done, err}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({phy_reset, ref_pad_sel, phy_en, lane_pwr, cr_req, done, err} == 0, "R1 idle after reset",
        {phy_reset, ref_pad_sel, phy_en, lane_pwr, cr_req, done, err}, 0);
    run(1'b1, 1'b1, 3'd0, 7'd0, 16'h1234, 0, 1000, 1'b0);
    run(1'b0, 1'b0, 3'd5, 7'd99, 16'hBEEF, 9, 1000, 1'b1);
    run(1'b1, 1'b0, 3'd2, 7'd10, 16'h0001, 10, 0, 1'b0);
    run(1'b0, 1'b0, 3'd7, 7'd127, 16'hFFFF, 3, 1000, 1'b0);
    run(1'b1, 1'b0, 3'd1, 7'd5, 16'h0F0F, 2, 4, 1'b0);
    for (int k = 0; k < 3; k++)
      run(1'($urandom), 1'($urandom), 3'($urandom), 7'($urandom), 16'($urandom),
          $urandom_range(0, 9), 1000, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule